// File: doc/BRIEF.md
# Chroma-Subsampled Frame Buffer Scanner

This block walks a display raster and produces the read addresses needed to refresh a screen whose frame buffer keeps one 8-bit luma sample for every pixel but only one U and one V sample for each 2×2 pixel group. For each pixel it issues a luma address and a chroma address. It takes the values that come back from synchronous frame-buffer memories with one cycle of latency. It then presents the aligned Y, U and V of that pixel, with its row and column, to a downstream YUV-to-RGB decoder through a registered hand-off stage. At the default 1600×1200 geometry and 30 frames per second, one pixel per clock needs a pixel clock near 57.6 MHz. A single decoder therefore has about 17.36 ns per pixel, and four decoders in parallel would each have four times that.

Two storage layouts are selectable by parameter. In the split layout, luma lives in its own array indexed by the full (row, col) position. Chroma lives in a second array indexed by (row/2, col/2), which is the position with the low bit of each counter dropped. In the packed layout, each 2×2 group is one wide word at a single address. The scanner then visits the four pixels of a group in the order top-left, top-right, bottom-left, bottom-right before it moves to the next group, and it picks the luma lane of the current pixel from the word. A one-cycle frame-start pulse marks the output of the first pixel of every frame.

Top module: `fb_yuv_scanner`

## Requirements
- R1: While reset is held and until the first enabled scan cycle, pix_valid and pix_sof are 0 and the issued luma, chroma and group addresses are all 0.
- R2: In the split layout, luma_addr equals row*H_PIX + col for the current scan position. The column advances fastest, by one per enabled cycle.
- R3: In the split layout, chroma_addr equals (row>>1)*(H_PIX/2) + (col>>1). Two horizontally adjacent pixels of one group therefore share a chroma address.
- R4: The column wraps from H_PIX-1 to 0 and advances the row. After the last pixel of a frame, the scan returns to row 0, column 0.
- R5: pix_sof is 1 for exactly the output cycle that carries the pixel at row 0, column 0 of each frame, and 0 in all other cycles.
- R6: A pixel issued in an enabled cycle appears with pix_valid = 1 two clock edges later. In the split layout, pix_y equals the luma word at its address. pix_u is bits [DW-1:0] and pix_v is bits [2*DW-1:DW] of the chroma word.
- R7: When scan_en is 0, the scan position and all issued addresses hold. Two edges later, pix_valid is 0 for that cycle.
- R8: In the packed layout, group_addr equals (row>>1)*(H_PIX/2) + (col>>1). The pixels of each group come in the order (2r,2c), (2r,2c+1), (2r+1,2c), (2r+1,2c+1), and groups follow in raster order.
- R9: In the packed layout, the group word holds luma lanes 0 to 3 in bits [4*DW-1:0], with lane = 2*(row&1) + (col&1) at bits [lane*DW +: DW]. U sits at [5*DW-1:4*DW] and V at [6*DW-1:5*DW].
- R10: pix_row and pix_col report the screen position of the pixel that is on the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Advance the scan by one pixel this cycle |
| luma_addr | output | $clog2(H_PIX*V_PIX) | Split layout: luma array read address (0 in packed layout) |
| chroma_addr | output | $clog2(H_PIX*V_PIX/4) | Split layout: chroma array read address (0 in packed layout) |
| group_addr | output | $clog2(H_PIX*V_PIX/4) | Packed layout: group word read address (0 in split layout) |
| luma_rdata | input | DW | Luma read data, one cycle after its address |
| chroma_rdata | input | 2*DW | Chroma read data {V,U}, one cycle after its address |
| group_rdata | input | 6*DW | Packed group word, one cycle after its address |
| pix_valid | output | 1 | Output pixel present |
| pix_sof | output | 1 | Output pixel is the first of a frame |
| pix_row | output | $clog2(V_PIX) | Row of the output pixel |
| pix_col | output | $clog2(H_PIX) | Column of the output pixel |
| pix_y | output | DW | Luma of the output pixel |
| pix_u | output | DW | U of the output pixel |
| pix_v | output | DW | V of the output pixel |

## Verification
The assertions take for granted that both frame dimensions are even. They also assume each memory returns data exactly one edge after its address, with no variable latency. If either assumption fails, the chroma pairing and the two-edge alignment of pix_valid stop meaning anything. The stimulus keeps within this. It instantiates an 8×6 geometry in both layouts and models every memory as a single register stage on the address. It drives scan_en only between clock edges, with an irregular stall pattern that stays well inside a frame, and runs long enough to cross the frame boundary more than twice.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic {
    LAYOUT_SPLIT  = 1'b0,
    LAYOUT_PACKED = 1'b1
  } layout_e;

  // Full-resolution luma index of a pixel.
  function automatic int unsigned luma_index(input int unsigned r,
                                             input int unsigned c,
                                             input int unsigned width);
    return r * width + c;
  endfunction

  // Index of the 2x2 group holding a pixel; serves both the split chroma
  // array and the packed group array.
  function automatic int unsigned quad_index(input int unsigned r,
                                             input int unsigned c,
                                             input int unsigned width);
    return (r >> 1) * (width >> 1) + (c >> 1);
  endfunction

  // Position of a pixel's luma inside a packed group word.
  function automatic int unsigned lane_of(input logic row_lsb,
                                          input logic col_lsb);
    return {30'd0, row_lsb, col_lsb};
  endfunction

endpackage

// File: rtl/fsb_scan_ctr.sv
module fsb_scan_ctr #(
  parameter int unsigned     H_PIX  = 1600,
  parameter int unsigned     V_PIX  = 1200,
  parameter fsb_pkg::layout_e LAYOUT = fsb_pkg::LAYOUT_SPLIT,
  parameter int unsigned     CW     = $clog2(H_PIX),
  parameter int unsigned     RW     = $clog2(V_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          last_pix,
  output logic          first_pix
);

  localparam int unsigned GCW = CW - 1;
  localparam int unsigned GRW = RW - 1;

  generate
    if (LAYOUT == fsb_pkg::LAYOUT_SPLIT) begin : g_raster
      logic [CW-1:0] col_q;
      logic [RW-1:0] row_q;
      logic          col_end;
      logic          row_end;

      assign col_end = (col_q == CW'(H_PIX - 1));
      assign row_end = (row_q == RW'(V_PIX - 1));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          col_q <= '0;
          row_q <= '0;
        end else if (adv) begin
          if (col_end) begin
            col_q <= '0;
            row_q <= row_end ? '0 : row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
      end

      assign row      = row_q;
      assign col      = col_q;
      assign last_pix = col_end && row_end;
    end else begin : g_quad
      logic [1:0]     sub_q;
      logic [GCW-1:0] gc_q;
      logic [GRW-1:0] gr_q;
      logic           sub_end;
      logic           gc_end;
      logic           gr_end;

      assign sub_end = (sub_q == 2'd3);
      assign gc_end  = (gc_q == GCW'(H_PIX / 2 - 1));
      assign gr_end  = (gr_q == GRW'(V_PIX / 2 - 1));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sub_q <= '0;
          gc_q  <= '0;
          gr_q  <= '0;
        end else if (adv) begin
          sub_q <= sub_q + 2'd1;
          if (sub_end) begin
            if (gc_end) begin
              gc_q <= '0;
              gr_q <= gr_end ? '0 : gr_q + 1'b1;
            end else begin
              gc_q <= gc_q + 1'b1;
            end
          end
        end
      end

      assign row      = {gr_q, sub_q[1]};
      assign col      = {gc_q, sub_q[0]};
      assign last_pix = sub_end && gc_end && gr_end;
    end
  endgenerate

  assign first_pix = (row == '0) && (col == '0);

endmodule

// File: rtl/fsb_addr_gen.sv
module fsb_addr_gen #(
  parameter int unsigned      H_PIX   = 1600,
  parameter fsb_pkg::layout_e LAYOUT  = fsb_pkg::LAYOUT_SPLIT,
  parameter int unsigned      CW      = 11,
  parameter int unsigned      RW      = 11,
  parameter int unsigned      LUMA_AW = 21,
  parameter int unsigned      GRP_AW  = 19
) (
  input  logic [RW-1:0]      row,
  input  logic [CW-1:0]      col,
  output logic [LUMA_AW-1:0] luma_addr,
  output logic [GRP_AW-1:0]  chroma_addr,
  output logic [GRP_AW-1:0]  group_addr
);

  logic [GRP_AW-1:0] quad_addr;

  assign quad_addr = GRP_AW'(fsb_pkg::quad_index(32'(row), 32'(col), H_PIX));

  generate
    if (LAYOUT == fsb_pkg::LAYOUT_SPLIT) begin : g_split
      assign luma_addr   = LUMA_AW'(fsb_pkg::luma_index(32'(row), 32'(col), H_PIX));
      assign chroma_addr = quad_addr;
      assign group_addr  = '0;
    end else begin : g_packed
      assign luma_addr   = '0;
      assign chroma_addr = '0;
      assign group_addr  = quad_addr;
    end
  endgenerate

endmodule

// File: rtl/fsb_out_stage.sv
module fsb_out_stage #(
  parameter fsb_pkg::layout_e LAYOUT = fsb_pkg::LAYOUT_SPLIT,
  parameter int unsigned      DW     = 8,
  parameter int unsigned      CW     = 11,
  parameter int unsigned      RW     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_fire,
  input  logic          issue_sof,
  input  logic [RW-1:0] issue_row,
  input  logic [CW-1:0] issue_col,
  input  logic [DW-1:0]   luma_rdata,
  input  logic [2*DW-1:0] chroma_rdata,
  input  logic [6*DW-1:0] group_rdata,
  output logic          fetch_valid,
  output logic          pix_valid,
  output logic          pix_sof,
  output logic [RW-1:0] pix_row,
  output logic [CW-1:0] pix_col,
  output logic [DW-1:0] pix_y,
  output logic [DW-1:0] pix_u,
  output logic [DW-1:0] pix_v
);

  logic          fetch_sof;
  logic [RW-1:0] fetch_row;
  logic [CW-1:0] fetch_col;
  logic [DW-1:0] sel_y;
  logic [DW-1:0] sel_u;
  logic [DW-1:0] sel_v;

  // Stage 1: tag travels alongside the memory read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      fetch_sof   <= 1'b0;
      fetch_row   <= '0;
      fetch_col   <= '0;
    end else begin
      fetch_valid <= issue_fire;
      fetch_sof   <= issue_fire && issue_sof;
      if (issue_fire) begin
        fetch_row <= issue_row;
        fetch_col <= issue_col;
      end
    end
  end

  generate
    if (LAYOUT == fsb_pkg::LAYOUT_SPLIT) begin : g_split
      wire unused_grp = ^{group_rdata, fetch_row[0]};
      assign sel_y = luma_rdata;
      assign sel_u = chroma_rdata[DW-1:0];
      assign sel_v = chroma_rdata[2*DW-1:DW];
    end else begin : g_packed
      wire unused_split = ^{luma_rdata, chroma_rdata};
      int unsigned lane;
      assign lane  = fsb_pkg::lane_of(fetch_row[0], fetch_col[0]);
      assign sel_y = group_rdata[lane*DW +: DW];
      assign sel_u = group_rdata[4*DW +: DW];
      assign sel_v = group_rdata[5*DW +: DW];
    end
  endgenerate

  // Stage 2: registered hand-off to the colour decoder.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_row   <= '0;
      pix_col   <= '0;
      pix_y     <= '0;
      pix_u     <= '0;
      pix_v     <= '0;
    end else begin
      pix_valid <= fetch_valid;
      pix_sof   <= fetch_sof;
      if (fetch_valid) begin
        pix_row <= fetch_row;
        pix_col <= fetch_col;
        pix_y   <= sel_y;
        pix_u   <= sel_u;
        pix_v   <= sel_v;
      end
    end
  end

endmodule

// File: rtl/fb_yuv_scanner.sv
module fb_yuv_scanner #(
  parameter int unsigned      H_PIX  = 1600,
  parameter int unsigned      V_PIX  = 1200,
  parameter int unsigned      DW     = 8,
  parameter fsb_pkg::layout_e LAYOUT = fsb_pkg::LAYOUT_SPLIT,
  localparam int unsigned     CW      = $clog2(H_PIX),
  localparam int unsigned     RW      = $clog2(V_PIX),
  localparam int unsigned     LUMA_AW = $clog2(H_PIX * V_PIX),
  localparam int unsigned     GRP_AW  = $clog2((H_PIX / 2) * (V_PIX / 2))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  output logic [LUMA_AW-1:0] luma_addr,
  output logic [GRP_AW-1:0]  chroma_addr,
  output logic [GRP_AW-1:0]  group_addr,
  input  logic [DW-1:0]      luma_rdata,
  input  logic [2*DW-1:0]    chroma_rdata,
  input  logic [6*DW-1:0]    group_rdata,
  output logic               pix_valid,
  output logic               pix_sof,
  output logic [RW-1:0]      pix_row,
  output logic [CW-1:0]      pix_col,
  output logic [DW-1:0]      pix_y,
  output logic [DW-1:0]      pix_u,
  output logic [DW-1:0]      pix_v
);

  // Named internal events, visible to the bound checker.
  logic [RW-1:0] scan_row;
  logic [CW-1:0] scan_col;
  logic          last_pix;
  logic          first_pix;
  logic          issue_sof;
  logic          fetch_valid;

  fsb_scan_ctr #(
    .H_PIX (H_PIX),
    .V_PIX (V_PIX),
    .LAYOUT(LAYOUT),
    .CW    (CW),
    .RW    (RW)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (scan_en),
    .row      (scan_row),
    .col      (scan_col),
    .last_pix (last_pix),
    .first_pix(first_pix)
  );

  fsb_addr_gen #(
    .H_PIX  (H_PIX),
    .LAYOUT (LAYOUT),
    .CW     (CW),
    .RW     (RW),
    .LUMA_AW(LUMA_AW),
    .GRP_AW (GRP_AW)
  ) u_addr (
    .row        (scan_row),
    .col        (scan_col),
    .luma_addr  (luma_addr),
    .chroma_addr(chroma_addr),
    .group_addr (group_addr)
  );

  assign issue_sof = first_pix;

  fsb_out_stage #(
    .LAYOUT(LAYOUT),
    .DW    (DW),
    .CW    (CW),
    .RW    (RW)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_fire  (scan_en),
    .issue_sof   (issue_sof),
    .issue_row   (scan_row),
    .issue_col   (scan_col),
    .luma_rdata  (luma_rdata),
    .chroma_rdata(chroma_rdata),
    .group_rdata (group_rdata),
    .fetch_valid (fetch_valid),
    .pix_valid   (pix_valid),
    .pix_sof     (pix_sof),
    .pix_row     (pix_row),
    .pix_col     (pix_col),
    .pix_y       (pix_y),
    .pix_u       (pix_u),
    .pix_v       (pix_v)
  );

endmodule

// File: rtl/fb_yuv_scanner_chk.sv
module fb_yuv_scanner_chk #(
  parameter int unsigned      H_PIX   = 1600,
  parameter int unsigned      V_PIX   = 1200,
  parameter fsb_pkg::layout_e LAYOUT  = fsb_pkg::LAYOUT_SPLIT,
  parameter int unsigned      CW      = 11,
  parameter int unsigned      RW      = 11,
  parameter int unsigned      LUMA_AW = 21,
  parameter int unsigned      GRP_AW  = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic [RW-1:0]      scan_row,
  input logic [CW-1:0]      scan_col,
  input logic               last_pix,
  input logic               fetch_valid,
  input logic               pix_valid,
  input logic               pix_sof,
  input logic [RW-1:0]      pix_row,
  input logic [CW-1:0]      pix_col,
  input logic [LUMA_AW-1:0] luma_addr,
  input logic [GRP_AW-1:0]  chroma_addr,
  input logic [GRP_AW-1:0]  group_addr
);

  wire unused_chk = ^{luma_addr, chroma_addr, group_addr};

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(scan_row) && $stable(scan_col)));

  assert_wrap_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && last_pix) |=> (scan_row == '0 && scan_col == '0));

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(scan_row) < V_PIX) && (32'(scan_col) < H_PIX));

  assert_fetch_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> fetch_valid);

  assert_stall_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !fetch_valid);

  assert_out_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> pix_valid);

  assert_sof_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> (pix_valid && pix_row == '0 && pix_col == '0));

  generate
    if (LAYOUT == fsb_pkg::LAYOUT_SPLIT) begin : g_split
      // Stepping from an even to an odd column stays in the same group.
      assert_chroma_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !scan_col[0]) |=> (chroma_addr == $past(chroma_addr)));

      assert_luma_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && scan_col != CW'(H_PIX - 1)) |=>
          (luma_addr == LUMA_AW'($past(luma_addr) + 1'b1)));
    end else begin : g_packed
      // Group address only moves after the bottom-right pixel of a group.
      assert_group_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !(scan_row[0] && scan_col[0])) |=> $stable(group_addr));
    end
  endgenerate

endmodule

bind fb_yuv_scanner fb_yuv_scanner_chk #(
  .H_PIX  (H_PIX),
  .V_PIX  (V_PIX),
  .LAYOUT (LAYOUT),
  .CW     (CW),
  .RW     (RW),
  .LUMA_AW(LUMA_AW),
  .GRP_AW (GRP_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .scan_row   (scan_row),
  .scan_col   (scan_col),
  .last_pix   (last_pix),
  .fetch_valid(fetch_valid),
  .pix_valid  (pix_valid),
  .pix_sof    (pix_sof),
  .pix_row    (pix_row),
  .pix_col    (pix_col),
  .luma_addr  (luma_addr),
  .chroma_addr(chroma_addr),
  .group_addr (group_addr)
);

// File: tb/fb_yuv_scanner_tb.sv
`timescale 1ns/100ps
module fb_yuv_scanner_tb;

  localparam int H  = 8;
  localparam int V  = 6;
  localparam int HV = H * V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int iss_n[2];
  int out_n[2];
  bit en_q1 = 1'b0;
  bit en_q2 = 1'b0;

  // Memory contents computed from the address.
  function automatic logic [7:0] yv(input int a); return 8'(a * 37 + 11); endfunction
  function automatic logic [7:0] uv(input int a); return 8'(a * 53 + 5); endfunction
  function automatic logic [7:0] vv(input int a); return 8'(a * 29 + 200); endfunction

  function automatic logic [47:0] pack_group(input int g);
    int gr, gc, base;
    gr = g / (H / 2);
    gc = g % (H / 2);
    base = 2 * gr * H + 2 * gc;
    return {vv(g), uv(g), yv(base + H + 1), yv(base + H), yv(base + 1), yv(base)};
  endfunction

  // Scan order: mode 0 raster, mode 1 group by group.
  task automatic exp_pos(input int mode, input int n, output int r, output int c);
    int k, g, s;
    k = n % HV;
    if (mode == 0) begin
      r = k / H;
      c = k % H;
    end else begin
      g = k / 4;
      s = k % 4;
      r = 2 * (g / (H / 2)) + s / 2;
      c = 2 * (g % (H / 2)) + s % 2;
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Split-layout instance
  logic [5:0]  s_luma_addr;
  logic [3:0]  s_chroma_addr, s_group_addr;
  logic [7:0]  s_luma_q;
  logic [15:0] s_chroma_q;
  logic        s_valid, s_sof;
  logic [2:0]  s_row, s_col;
  logic [7:0]  s_y, s_u, s_v;

  fb_yuv_scanner #(.H_PIX(H), .V_PIX(V), .DW(8), .LAYOUT(fsb_pkg::LAYOUT_SPLIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .luma_addr(s_luma_addr), .chroma_addr(s_chroma_addr), .group_addr(s_group_addr),
    .luma_rdata(s_luma_q), .chroma_rdata(s_chroma_q), .group_rdata(48'd0),
    .pix_valid(s_valid), .pix_sof(s_sof), .pix_row(s_row), .pix_col(s_col),
    .pix_y(s_y), .pix_u(s_u), .pix_v(s_v)
  );

  // Packed-layout instance
  logic [5:0]  p_luma_addr;
  logic [3:0]  p_chroma_addr, p_group_addr;
  logic [47:0] p_group_q;
  logic        p_valid, p_sof;
  logic [2:0]  p_row, p_col;
  logic [7:0]  p_y, p_u, p_v;

  fb_yuv_scanner #(.H_PIX(H), .V_PIX(V), .DW(8), .LAYOUT(fsb_pkg::LAYOUT_PACKED)) u_dut_packed (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .luma_addr(p_luma_addr), .chroma_addr(p_chroma_addr), .group_addr(p_group_addr),
    .luma_rdata(8'd0), .chroma_rdata(16'd0), .group_rdata(p_group_q),
    .pix_valid(p_valid), .pix_sof(p_sof), .pix_row(p_row), .pix_col(p_col),
    .pix_y(p_y), .pix_u(p_u), .pix_v(p_v)
  );

  // One-cycle synchronous memories.
  always_ff @(posedge clk) begin
    s_luma_q   <= yv(int'(s_luma_addr));
    s_chroma_q <= {vv(int'(s_chroma_addr)), uv(int'(s_chroma_addr))};
    p_group_q  <= pack_group(int'(p_group_addr));
  end

  task automatic side(input int mode, input int addr, input int caddr,
                      input bit vld, input bit sof, input int prow, input int pcol,
                      input int py, input int pu, input int pv);
    int r, c, q;
    exp_pos(mode, iss_n[mode], r, c);
    q = (r / 2) * (H / 2) + c / 2;
    if (mode == 0) begin
      chk_eq(en_q1 ? "R2 luma addr" : "R7 luma addr held", addr, r * H + c);
      chk_eq(en_q1 ? "R3 chroma addr" : "R7 chroma addr held", caddr, q);
    end else begin
      chk_eq(en_q1 ? "R8 group addr" : "R7 group addr held", addr, q);
    end
    if (iss_n[mode] > 0 && iss_n[mode] % HV == 0)
      chk_eq("R4 frame wrap to origin", addr, 0);
    chk_eq(en_q2 ? "R6 valid after two edges" : "R7 no valid after stall", int'(vld), int'(en_q2));
    if (vld) begin
      exp_pos(mode, out_n[mode], r, c);
      q = (r / 2) * (H / 2) + c / 2;
      chk_eq("R10 pixel row", prow, r);
      chk_eq("R10 pixel col", pcol, c);
      chk_eq(mode == 0 ? "R6 luma data" : "R9 luma lane", py, int'(yv(r * H + c)));
      chk_eq(mode == 0 ? "R6 U data" : "R9 U lane", pu, int'(uv(q)));
      chk_eq(mode == 0 ? "R6 V data" : "R9 V lane", pv, int'(vv(q)));
      chk_eq("R5 sof on origin pixel", int'(sof), int'(out_n[mode] % HV == 0));
      out_n[mode]++;
    end else begin
      chk_eq("R5 sof idle", int'(sof), 0);
    end
  endtask

  initial begin
    iss_n[0] = 0; iss_n[1] = 0; out_n[0] = 0; out_n[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_eq("R1 valid in reset", int'(s_valid) + int'(p_valid), 0);
    chk_eq("R1 sof in reset", int'(s_sof) + int'(p_sof), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 luma addr after reset", int'(s_luma_addr), 0);
    chk_eq("R1 chroma addr after reset", int'(s_chroma_addr), 0);
    chk_eq("R1 group addr after reset", int'(p_group_addr), 0);
    chk_eq("R1 valid after reset", int'(s_valid) + int'(p_valid), 0);
    for (int cyc = 0; cyc < 300; cyc++) begin
      bit nen;
      @(negedge clk);
      side(0, int'(s_luma_addr), int'(s_chroma_addr), s_valid, s_sof,
           int'(s_row), int'(s_col), int'(s_y), int'(s_u), int'(s_v));
      side(1, int'(p_group_addr), 0, p_valid, p_sof,
           int'(p_row), int'(p_col), int'(p_y), int'(p_u), int'(p_v));
      nen = !((cyc % 7) == 3 || (cyc % 11) == 5 || (cyc >= 120 && cyc < 124));
      en_q2 = en_q1;
      en_q1 = nen;
      scan_en = nen;
      if (nen) begin
        iss_n[0]++;
        iss_n[1]++;
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule